// File: doc/BRIEF.md
# Full Chip Erase Sequencer

This block carries out a whole-array erase by stepping through every erase block of a flash array and erasing only the blocks that are not write-protected. A single confirm pulse starts a run. At that moment the block takes a snapshot of the per-block protection vector from the lock checker. It then issues one erase command per unprotected block, always from block 0 upward. For each command it gives the array a one-cycle strobe with the block index, and the array answers by filling that block with all-ones words (FFFFH).

The time each block erase takes is modelled by an internal countdown. Its length comes from a programmable cycle count. On the last cycle of that window the block samples the array's verify result. A failing verify ends the run at once, and no further blocks are touched. When every block is protected, the run ends with both the erase-error and the protection-fault flags set. Busy, a one-cycle done pulse and the two sticky fault flags go to the status logic. A full-array erase cannot be suspended. A synchronous reset abandons a run on the spot and leaves whatever was already erased as it is.

Top module: `chip_erase_seq`

## Requirements
- R1: A start pulse seen while idle raises `busy_o` on the next cycle and clears `err_o` and `lock_fault_o`, which otherwise keep their value until the next accepted start.
- R2: The protection vector `lock_i` (bit k high = block k protected) is captured in the cycle the start is accepted; changes to `lock_i` during a run have no effect on which blocks are erased.
- R3: Each unprotected block receives exactly one erase strobe (`erase_stb_o` high for one cycle with `erase_blk_o` = block index), in strictly ascending index order, and only while `busy_o` is high.
- R4: A protected block never receives an erase strobe, so its contents are left as they were.
- R5: Each block erase lasts `erase_len_i` cycles counted from the cycle after its strobe (a value of 0 is treated as 1), and `verify_fail_i` is sampled on the final cycle of that window.
- R6: A failing verify ends the run: `err_o` is set, `lock_fault_o` stays low, and no block with a higher index is strobed.
- R7: If every block is protected, no strobe is issued, and the run ends after one busy cycle with `err_o` and `lock_fault_o` both set.
- R8: `busy_o` stays high from the cycle after the start until the run ends. The busy length is n*(1+L) cycles when the run ends on a failure or on the last block, and n*(1+L)+1 otherwise, where n is the number of strobes and L the effective erase length. `done_o` pulses for exactly one cycle, in the first cycle with `busy_o` low.
- R9: A start pulse during a run, including a start held high for two cycles, is ignored.
- R10: A synchronous reset clears `busy_o`, `done_o`, `err_o`, `lock_fault_o` and `erase_stb_o` at the next edge, stops the run without a done pulse, and leaves blocks already erased in their erased state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Confirm pulse that starts a full erase |
| lock_i | input | NBLK | Per-block protection vector, 1 = protected |
| erase_len_i | input | DW | Erase window length in cycles per block, 0 means 1 |
| verify_fail_i | input | 1 | Array verify result, 1 = the current block failed |
| erase_stb_o | output | 1 | One-cycle erase command to the array |
| erase_blk_o | output | BW | Index of the block being erased |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse when a run ends |
| err_o | output | 1 | Sticky erase-error flag |
| lock_fault_o | output | 1 | Sticky flag: all blocks were protected |

## Verification
The bench targets several corner cases. One is a fully protected array: a design that got it wrong would either hang or report success without a fault. Another is a failure on block 0 or on the last block: a wrong design would keep erasing past the failure or miss the error. The bench also runs an unprotected top block, where the run must end without an extra scan cycle, and a zero erase length, which a wrong design would take as a huge or empty window. It also flips the protection vector and re-pulses start in the middle of a run, which catches designs that read the live lock vector or restart. Finally, it resets the block in the middle of a run, where a wrong design would keep strobing or emit a stray done pulse.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_ERASE = 2'd2
  } fcs_state_e;
endpackage

// File: rtl/fcs_scan.sv
// Finds the lowest-indexed erasable block at or above a starting index.
module fcs_scan #(
  parameter int NBLK = 39,
  parameter int BW   = $clog2(NBLK)
) (
  input  logic [NBLK-1:0] avail_i,
  input  logic [BW-1:0]   from_i,
  output logic            found_o,
  output logic [BW-1:0]   idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = NBLK - 1; i >= 0; i--) begin
      if (avail_i[i] && (i >= int'(from_i))) begin
        found_o = 1'b1;
        idx_o   = BW'(i);
      end
    end
  end
endmodule

// File: rtl/fcs_timer.sv
// Models the per-block erase duration as a loadable countdown.
module fcs_timer #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [DW-1:0] len_i,
  output logic          expire_o
);
  logic [DW-1:0] cnt_q;
  logic          act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= (len_i == '0) ? DW'(1) : len_i;
      act_q <= 1'b1;
    end else if (act_q) begin
      if (cnt_q == DW'(1)) act_q <= 1'b0;
      else                 cnt_q <= cnt_q - DW'(1);
    end
  end

  assign expire_o = act_q && (cnt_q == DW'(1));
endmodule

// File: rtl/chip_erase_seq.sv
module chip_erase_seq #(
  parameter int NBLK = 39,
  parameter int DW   = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start_i,
  input  logic [NBLK-1:0]          lock_i,
  input  logic [DW-1:0]            erase_len_i,
  input  logic                     verify_fail_i,
  output logic                     erase_stb_o,
  output logic [$clog2(NBLK)-1:0]  erase_blk_o,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     err_o,
  output logic                     lock_fault_o
);
  import fcs_pkg::*;

  localparam int BW = $clog2(NBLK);
  localparam logic [BW-1:0] LAST = BW'(NBLK - 1);

  fcs_state_e      state_q;
  logic [NBLK-1:0] lock_q;
  logic [BW-1:0]   cur_q;
  logic            any_q;
  logic            found;
  logic [BW-1:0]   next_idx;
  logic            expire;
  logic            load;

  fcs_scan #(.NBLK(NBLK), .BW(BW)) u_scan (
    .avail_i (~lock_q),
    .from_i  (cur_q),
    .found_o (found),
    .idx_o   (next_idx)
  );

  assign load = (state_q == ST_SCAN) && found;

  fcs_timer #(.DW(DW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load_i   (load),
    .len_i    (erase_len_i),
    .expire_o (expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      lock_q       <= '0;
      cur_q        <= '0;
      any_q        <= 1'b0;
      erase_stb_o  <= 1'b0;
      erase_blk_o  <= '0;
      busy_o       <= 1'b0;
      done_o       <= 1'b0;
      err_o        <= 1'b0;
      lock_fault_o <= 1'b0;
    end else begin
      erase_stb_o <= 1'b0;
      done_o      <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            lock_q       <= lock_i;
            cur_q        <= '0;
            any_q        <= 1'b0;
            err_o        <= 1'b0;
            lock_fault_o <= 1'b0;
            busy_o       <= 1'b1;
            state_q      <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (found) begin
            erase_blk_o <= next_idx;
            erase_stb_o <= 1'b1;
            any_q       <= 1'b1;
            state_q     <= ST_ERASE;
          end else begin
            busy_o  <= 1'b0;
            done_o  <= 1'b1;
            state_q <= ST_IDLE;
            if (!any_q) begin
              err_o        <= 1'b1;
              lock_fault_o <= 1'b1;
            end
          end
        end
        ST_ERASE: begin
          if (expire) begin
            if (verify_fail_i || (erase_blk_o == LAST)) begin
              err_o   <= verify_fail_i;
              busy_o  <= 1'b0;
              done_o  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              cur_q   <= erase_blk_o + BW'(1);
              state_q <= ST_SCAN;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fcs_chk.sv
module fcs_chk #(
  parameter int NBLK = 39,
  parameter int BW   = $clog2(NBLK)
) (
  input logic            clk,
  input logic            rst,
  input logic            start_i,
  input logic [NBLK-1:0] lock_i,
  input logic            erase_stb_o,
  input logic [BW-1:0]   erase_blk_o,
  input logic            busy_o,
  input logic            done_o,
  input logic            err_o,
  input logic            lock_fault_o
);
  logic [NBLK-1:0] snap_q;
  logic            have_q;
  logic [BW-1:0]   last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_q <= '0;
      have_q <= 1'b0;
      last_q <= '0;
    end else if (start_i && !busy_o) begin
      snap_q <= lock_i;
      have_q <= 1'b0;
    end else if (erase_stb_o) begin
      have_q <= 1'b1;
      last_q <= erase_blk_o;
    end
  end

  a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  a_r3_stb_in_run: assert property (@(posedge clk) disable iff (rst)
    erase_stb_o |-> busy_o);
  a_r3_ascending: assert property (@(posedge clk) disable iff (rst)
    (erase_stb_o && have_q) |-> (erase_blk_o > last_q));
  a_r4_skip_locked: assert property (@(posedge clk) disable iff (rst)
    erase_stb_o |-> !snap_q[erase_blk_o]);
  a_r7_fault_has_err: assert property (@(posedge clk) disable iff (rst)
    lock_fault_o |-> err_o);
  a_r1_start_busy: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> busy_o);
endmodule

bind chip_erase_seq fcs_chk #(.NBLK(NBLK), .BW(BW)) u_fcs_chk (
  .clk          (clk),
  .rst          (rst),
  .start_i      (start_i),
  .lock_i       (lock_i),
  .erase_stb_o  (erase_stb_o),
  .erase_blk_o  (erase_blk_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .err_o        (err_o),
  .lock_fault_o (lock_fault_o)
);

// File: tb/tb_chip_erase_seq.sv
module tb_chip_erase_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NBLK = 39;
  localparam int DW   = 8;
  localparam int BW   = $clog2(NBLK);

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            start_i = 1'b0;
  logic [NBLK-1:0] lock_i = '0;
  logic [DW-1:0]   erase_len_i = DW'(1);
  logic            verify_fail_i = 1'b0;
  logic            erase_stb_o;
  logic [BW-1:0]   erase_blk_o;
  logic            busy_o, done_o, err_o, lock_fault_o;

  chip_erase_seq #(.NBLK(NBLK), .DW(DW)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, fails = 0;
  int seen [64];
  int nseen = 0, busy_cnt = 0, done_cnt = 0, cycles = 0;
  int fail_idx = -1;
  logic [15:0] mem [NBLK];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  // array and erase-engine model, observed away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (erase_stb_o) begin
      if (nseen < 64) seen[nseen] = int'(erase_blk_o);
      nseen++;
      if (int'(erase_blk_o) < NBLK) mem[erase_blk_o] = 16'hFFFF;
    end
    if (busy_o) busy_cnt++;
    if (done_o) done_cnt++;
    verify_fail_i = busy_o && (int'(erase_blk_o) == fail_idx);
  end

  initial begin
    #(CLK_PERIOD * 150000);
    total++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  task automatic run_case(input logic [NBLK-1:0] lk, input int len,
                          input int fidx, input bit disturb);
    int exp_list [64];
    int n = 0, last = -1, el, ebusy, wait_n = 0;
    bit hit = 0, direct;
    for (int i = 0; i < NBLK; i++) mem[i] = 16'h1000 + 16'(i);
    nseen = 0; busy_cnt = 0; done_cnt = 0; fail_idx = fidx;
    @(negedge clk);
    lock_i = lk; erase_len_i = DW'(len); start_i = 1'b1;
    @(negedge clk);
    if (disturb) begin
      start_i = 1'b1;            // R9: start held a second cycle
      @(negedge clk);
      start_i = 1'b0;
      lock_i = ~lk;              // R2: live vector changes mid-run
    end else begin
      start_i = 1'b0;
    end
    while (done_cnt == 0 && wait_n < 5000) begin
      @(negedge clk); wait_n++;
    end
    for (int i = 0; i < NBLK; i++) begin
      if (!lk[i]) begin
        exp_list[n] = i; n++; last = i;
        if (i == fidx) begin hit = 1; break; end
      end
    end
    el = (len == 0) ? 1 : len;
    direct = hit || (last == NBLK - 1);
    ebusy = n * (1 + el) + (direct ? 0 : 1);
    chk(done_cnt == 1, "R8", "done seen", done_cnt, 1);
    chk(busy_o == 1'b0, "R8", "busy low at done", busy_o, 0);
    chk(busy_cnt == ebusy, "R5", "busy length", busy_cnt, ebusy);
    chk(err_o == (hit || n == 0), "R6", "err flag", err_o, (hit || n == 0));
    chk(lock_fault_o == (n == 0), "R7", "lock fault", lock_fault_o, (n == 0));
    chk(nseen == n, "R3", "strobe count", nseen, n);
    for (int k = 0; k < n && k < nseen; k++)
      chk(seen[k] == exp_list[k], "R3", "strobe order", seen[k], exp_list[k]);
    for (int i = 0; i < NBLK; i++) begin
      bit er = 0;
      for (int k = 0; k < n; k++) if (exp_list[k] == i) er = 1;
      chk(mem[i] == (er ? 16'hFFFF : 16'h1000 + 16'(i)), "R4", "block contents",
          mem[i], er ? 16'hFFFF : 16'h1000 + 16'(i));
    end
    @(negedge clk);
    chk(done_o == 1'b0, "R8", "done one cycle", done_o, 0);
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy_o && !done_o && !err_o && !lock_fault_o && !erase_stb_o,
        "R10", "reset state", {busy_o, done_o, err_o, lock_fault_o}, 0);

    run_case('0, 1, -1, 0);                           // all erasable
    run_case('1, 3, -1, 0);                           // R7 all protected
    run_case('0, 2, -1, 0);                           // R1 flags cleared by new start
    chk(err_o == 1'b0, "R1", "err cleared on start", err_o, 0);
    run_case('0, 2, 0, 0);                            // R6 fail on block 0
    run_case(NBLK'(5), 1, NBLK - 1, 0);               // R6 fail on last block
    run_case({1'b0, {(NBLK-1){1'b1}}}, 2, -1, 0);     // only top block
    run_case({1'b1, {(NBLK-1){1'b0}}}, 0, -1, 1);     // R5 len 0, R2/R9 disturb
    run_case(NBLK'(36'hA5A5_0F0F3), 4, 7, 1);         // fail on a protected block

    for (int t = 0; t < 12; t++) begin
      logic [NBLK-1:0] lk;
      int len, fidx;
      lk = NBLK'({$urandom(), $urandom()});
      len = int'($urandom_range(0, 5));
      fidx = ($urandom_range(0, 1) == 1) ? int'($urandom_range(0, NBLK - 1)) : -1;
      run_case(lk, len, fidx, t[0]);
    end

    // R10: reset in the middle of a run
    for (int i = 0; i < NBLK; i++) mem[i] = 16'h1000 + 16'(i);
    nseen = 0; done_cnt = 0; fail_idx = -1;
    @(negedge clk);
    lock_i = '0; erase_len_i = DW'(4); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    while (nseen < 2) @(negedge clk);
    rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(!busy_o && !done_o && !err_o && !lock_fault_o, "R10", "abort clears",
        {busy_o, done_o, err_o, lock_fault_o}, 0);
    repeat (30) @(negedge clk);
    chk(nseen == 2, "R10", "no strobe after reset", nseen, 2);
    chk(done_cnt == 0, "R10", "no done after reset", done_cnt, 0);
    chk(mem[0] == 16'hFFFF && mem[1] == 16'hFFFF, "R10", "erased blocks kept",
        {mem[0], mem[1]}, 32'hFFFF_FFFF);
    chk(mem[2] == 16'h1002, "R10", "later block untouched", mem[2], 16'h1002);
    finish_run();
  end
endmodule